// File: doc/BRIEF.md
# Receive Frame FIFO Writer

This block sits between a byte-wide receive datapath and a 16-bit receive packet FIFO. Each frame arrives as a run of contiguous cycles with the byte-valid input high, and may carry an error strobe. The block pairs the bytes into 16-bit FIFO words and presents each word on a write port. When a frame ends, it emits a single end-of-frame pulse. Two status flags are qualified by that pulse: one marks a bad frame, and one marks a frame that hit a full FIFO during one of its writes.

A host can raise an asynchronous skip request to protect a FIFO that is filling up. The request passes through a two-flop synchroniser. It is then sampled only on the first byte of a frame, so each frame is either written in full or dropped in full. A dropped frame writes nothing and produces no status pulse. It is counted in a saturating dropped-frame counter. A word offered while the FIFO reports full is lost, but the frame still runs to its end-of-frame.

Top module: `rxfw_writer`

## Requirements
- R1: The skip request passes through two flops. A frame whose first byte arrives within one clock of the request rising is still written. A frame starting two or more clocks after the request rises is dropped.
- R2: While the synchronised skip request is high when a frame starts, that frame produces no write and no end-of-frame pulse. It increments `drop_count`.
- R3: The skip decision is taken on the first byte of a frame. A change of the skip request during a frame affects only later frames.
- R4: Bytes are paired in arrival order. The first byte of a pair goes to `wr_data[7:0]` and the second to `wr_data[15:8]`, with `wr_bvalid` = 2'b11. The word is offered in the cycle in which the second byte is on the input.
- R5: An odd final byte is offered in the first cycle after `in_valid` falls. It appears on `wr_data[7:0]`, with `wr_data[15:8]` = 8'h00 and `wr_bvalid` = 2'b01.
- R6: `eof` is high for exactly one cycle, the cycle after the first idle cycle that follows a kept frame.
- R7: `frame_err` is high together with `eof` when `in_err` was seen on any valid byte of the frame or the frame had an odd byte count. Otherwise it is low.
- R8: A word offered while `fifo_full` is high is not written (`wr_en` low). The frame still ends with `eof`, and `fifo_err` is high with it. `fifo_err` is low when `eof` is low.
- R9: `drop_count` is CNT_W bits wide (16 by default) and holds at all ones once it gets there.
- R10: Synchronous active-high `rst` clears the counter, the flags, any pending odd byte and the frame state. No write or `eof` follows from a frame cut off by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte valid; high for the whole frame |
| in_byte | input | 8 | Received byte |
| in_err | input | 1 | Receive error strobe for the current byte |
| skip_async | input | 1 | Host request to drop frames, asynchronous |
| fifo_full | input | 1 | FIFO cannot accept a word this cycle |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 16 | FIFO write word, first byte in the low half |
| wr_bvalid | output | 2 | Byte-valid lanes of the word, bit 0 for the low byte |
| eof | output | 1 | End-of-frame pulse for a kept frame |
| frame_err | output | 1 | Frame had an error or an odd byte; valid with eof |
| fifo_err | output | 1 | A word of the frame met a full FIFO; valid with eof |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
Some properties are checked on every cycle: that `eof` lasts one cycle, that both flags appear only together with `eof`, that a paired word carries the previous cycle's byte in its low half, that a tail word follows a valid cycle with a zero upper byte, that nothing is written inside a dropped frame, and that the counter holds once saturated. Other behaviours need whole scenarios in the bench. These are the exact word contents and their order, which words a full FIFO removes, the synchroniser's one-clock blind window, mid-frame skip changes, the effect of a reset cut, and the counter reaching its ceiling.

// File: rtl/rxfw_pkg.sv
package rxfw_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  // saturating increment toward a ceiling
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] ceil);
    return (v >= ceil) ? ceil : v + 32'd1;
  endfunction

  // place two bytes in a FIFO word, earlier byte in the low half
  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] later,
                                                   input logic [BYTE_W-1:0] earlier);
    return {later, earlier};
  endfunction
endpackage

// File: rtl/rxfw_sync.sv
module rxfw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxfw_packer.sv
module rxfw_packer
  import rxfw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              end_c,
  input  logic              drop_now,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_bvalid,
  output logic              attempt,
  output logic              odd_pend
);
  logic [BYTE_W-1:0] lo_q;
  logic              half_q;
  logic              pair_ev;
  logic              tail_ev;

  assign pair_ev  = in_valid & half_q & ~drop_now;
  assign tail_ev  = end_c & half_q & ~drop_now;
  assign attempt  = pair_ev | tail_ev;
  assign odd_pend = end_c & half_q;
  assign wr_en    = attempt & ~fifo_full;
  assign wr_data  = tail_ev ? join_bytes('0, lo_q) : join_bytes(in_byte, lo_q);
  assign wr_bvalid = tail_ev ? 2'b01 : (pair_ev ? 2'b11 : 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      half_q <= 1'b0;
    end else if (in_valid && !drop_now) begin
      if (!half_q) begin
        lo_q   <= in_byte;
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
      end
    end else if (end_c) begin
      half_q <= 1'b0;
    end
  end

  assert_pair_order_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bvalid == 2'b11) |-> (wr_data[7:0] == $past(in_byte)));

  assert_tail_shape_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bvalid == 2'b01) |-> ($past(in_valid) && !in_valid && wr_data[15:8] == 8'h00));
endmodule

// File: rtl/rxfw_status.sv
module rxfw_status
  import rxfw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             end_c,
  input  logic             drop_now,
  input  logic             skip_s,
  input  logic             in_valid,
  input  logic             in_err,
  input  logic             attempt,
  input  logic             fifo_full,
  input  logic             odd_pend,
  output logic             eof,
  output logic             frame_err,
  output logic             fifo_err,
  output logic [CNT_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic err_acc;
  logic full_acc;
  logic err_base;
  logic full_base;
  logic keep_end;

  assign err_base  = start ? 1'b0 : err_acc;
  assign full_base = start ? 1'b0 : full_acc;
  assign keep_end  = end_c & ~drop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_acc    <= 1'b0;
      full_acc   <= 1'b0;
      eof        <= 1'b0;
      frame_err  <= 1'b0;
      fifo_err   <= 1'b0;
      drop_count <= '0;
    end else begin
      err_acc   <= err_base | (in_valid & in_err);
      full_acc  <= full_base | (attempt & fifo_full);
      eof       <= keep_end;
      frame_err <= keep_end & (err_acc | odd_pend);
      fifo_err  <= keep_end & (full_acc | (attempt & fifo_full));
      if (start && skip_s)
        drop_count <= CNT_W'(sat_step(32'(drop_count), 32'(CNT_MAX)));
    end
  end

  assert_eof_single_R6: assert property (@(posedge clk) disable iff (rst)
    eof |=> !eof);

  assert_ferr_qual_R7: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> eof);

  assert_fifoerr_qual_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_err |-> eof);

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));
endmodule

// File: rtl/rxfw_writer.sv
module rxfw_writer
  import rxfw_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_err,
  input  logic              skip_async,
  input  logic              fifo_full,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_bvalid,
  output logic              eof,
  output logic              frame_err,
  output logic              fifo_err,
  output logic [CNT_W-1:0]  drop_count
);
  logic skip_s;
  logic prev_q;
  logic drop_q;
  logic start;
  logic end_c;
  logic drop_now;
  logic attempt;
  logic odd_pend;

  rxfw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(skip_async), .q(skip_s)
  );

  // frame boundaries from the valid edges; skip decision frozen at start
  assign start    = in_valid & ~prev_q;
  assign end_c    = prev_q & ~in_valid;
  assign drop_now = start ? skip_s : drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      prev_q <= in_valid;
      if (start) drop_q <= skip_s;
    end
  end

  rxfw_packer u_pack (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .end_c(end_c), .drop_now(drop_now), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bvalid(wr_bvalid),
    .attempt(attempt), .odd_pend(odd_pend)
  );

  rxfw_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst(rst), .start(start), .end_c(end_c), .drop_now(drop_now),
    .skip_s(skip_s), .in_valid(in_valid), .in_err(in_err), .attempt(attempt),
    .fifo_full(fifo_full), .odd_pend(odd_pend), .eof(eof),
    .frame_err(frame_err), .fifo_err(fifo_err), .drop_count(drop_count)
  );

  assert_drop_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (drop_q && prev_q && in_valid) |-> !wr_en);

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
    (start && skip_s) |-> $past(skip_async));
endmodule

// File: tb/tb_rxfw_writer.sv
module tb_rxfw_writer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_err = 1'b0;
  logic        skip_async = 1'b0;
  logic        fifo_full = 1'b0;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [1:0]  wr_bvalid;
  logic        eof;
  logic        frame_err;
  logic        fifo_err;
  logic [15:0] drop_count;

  int total = 0;
  int bad = 0;
  int drops_model = 0;

  logic [17:0] exp_w[$];
  string       tag_w[$];
  logic [1:0]  exp_e[$];
  string       tag_e[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfw_writer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_err(in_err), .skip_async(skip_async), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bvalid(wr_bvalid), .eof(eof),
    .frame_err(frame_err), .fifo_err(fifo_err), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: pop expected items as the design emits them
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R2", "unexpected write", {14'd0, wr_bvalid, wr_data}, 32'h0);
        end else begin
          logic [17:0] e;
          string t;
          e = exp_w.pop_front();
          t = tag_w.pop_front();
          check({wr_bvalid, wr_data} == e, t, "write word", {14'd0, wr_bvalid, wr_data}, {14'd0, e});
        end
      end
      if (eof) begin
        if (exp_e.size() == 0) begin
          check(1'b0, "R6", "unexpected eof", {30'd0, frame_err, fifo_err}, 32'h0);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_e.pop_front();
          t = tag_e.pop_front();
          check({frame_err, fifo_err} == e, t, "eof flags", {30'd0, frame_err, fifo_err}, {30'd0, e});
        end
      end else begin
        if (frame_err || fifo_err)
          check(1'b0, "R8", "flag without eof", {30'd0, frame_err, fifo_err}, 32'h0);
      end
    end
  end

  // driver: predicts from the requirements, then drives the frame
  task automatic send(input int n, input logic [7:0] base, input int err_at,
                      input int full_at, input int skip_at, input bit drop, input string tag);
    if (!drop) begin
      for (int w = 0; w < n / 2; w++) begin
        if (w != full_at) begin
          exp_w.push_back({2'b11, 8'(base + 2*w + 1), 8'(base + 2*w)});
          tag_w.push_back(tag);
        end
      end
      if ((n % 2 == 1) && (full_at != n / 2)) begin
        exp_w.push_back({2'b01, 8'h00, 8'(base + n - 1)});
        tag_w.push_back("R5");
      end
      exp_e.push_back({(err_at >= 0) || (n % 2 == 1), (full_at >= 0) && (full_at < (n + 1) / 2)});
      tag_e.push_back(tag);
    end else begin
      if (drops_model < 65535) drops_model++;
    end
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid  = 1'b1;
      in_byte   = 8'(base + i);
      in_err    = (i == err_at);
      fifo_full = (i % 2 == 1) && (i / 2 == full_at);
      if (i == skip_at) skip_async = ~skip_async;
    end
    @(posedge clk); #1;
    in_valid  = 1'b0;
    in_err    = 1'b0;
    fifo_full = (n % 2 == 1) && (full_at == n / 2);
    @(posedge clk); #1;
    fifo_full = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!wr_en && !eof && drop_count == 16'd0, "R10", "reset state",
          {15'd0, wr_en, eof, drop_count}, 32'd0);
    @(posedge clk); #1 rst = 1'b0;

    send(4, 8'h10, -1, -1, -1, 1'b0, "R4");
    send(5, 8'h20, -1, -1, -1, 1'b0, "R5");
    send(6, 8'h30,  2, -1, -1, 1'b0, "R7");
    send(4, 8'h40, -1,  1, -1, 1'b0, "R8");
    send(3, 8'h50, -1,  1, -1, 1'b0, "R8");

    // R1: one-clock blind window, then drop
    @(posedge clk); #1 skip_async = 1'b1;
    send(2, 8'h60, -1, -1, -1, 1'b0, "R1");
    send(3, 8'h70, -1, -1, -1, 1'b1, "R2");
    @(negedge clk);
    check(drop_count == 16'(drops_model), "R2", "drop count after drop", {16'd0, drop_count}, drops_model);
    skip_async = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    send(2, 8'h80, -1, -1, -1, 1'b0, "R1");

    // R3: mid-frame raise keeps frame, mid-frame clear keeps dropping
    send(4, 8'h90, -1, -1, 1, 1'b0, "R3");
    send(2, 8'hA0, -1, -1, 1, 1'b1, "R3");
    send(2, 8'hA8, -1, -1, -1, 1'b0, "R3");
    @(negedge clk);
    check(drop_count == 16'(drops_model), "R3", "drop count after mid-frame change", {16'd0, drop_count}, drops_model);

    // R10: reset with a pending odd byte
    @(posedge clk); #1;
    in_valid = 1'b1; in_byte = 8'hEE;
    @(posedge clk); #1;
    in_valid = 1'b0; rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    drops_model = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(drop_count == 16'd0 && !eof, "R10", "state after reset cut", {15'd0, eof, drop_count}, 32'd0);
    #1;
    send(2, 8'hC0, -1, -1, -1, 1'b0, "R10");

    // R9: drive the counter to its ceiling
    @(posedge clk); #1 skip_async = 1'b1;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 65540; k++) begin
      @(posedge clk); #1 in_valid = 1'b1; in_byte = 8'h5A;
      @(posedge clk); #1 in_valid = 1'b0;
      if (drops_model < 65535) drops_model++;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(drop_count == 16'hFFFF, "R9", "saturated count", {16'd0, drop_count}, 32'h0000FFFF);
    check(drops_model == 65535, "R9", "model ceiling", drops_model, 32'h0000FFFF);
    skip_async = 1'b0;
    repeat (4) @(posedge clk);

    check(exp_w.size() == 0, "R4", "writes left unseen", exp_w.size(), 32'd0);
    check(exp_e.size() == 0, "R6", "eof pulses left unseen", exp_e.size(), 32'd0);
    summary();
    $finish;
  end
endmodule